// File: doc/BRIEF.md
# Linked Descriptor List Interrupt Walker

This block services polled interrupt requests by following chains of device descriptors held in a word-addressed memory. A pulse on `start_i` begins a service run. The walker takes the most urgent pending level, withdraws that level's request, and reads a per-level vector table. The entry it reads is the head of a linked list of descriptors.

For each descriptor, the walker fetches the device type word and presents it, with the level, on a dispatch handshake. It holds the dispatch until the external handler acknowledges. Only after that acknowledge does it read the link word and move to the next descriptor. A link value of zero ends the list. At the end of each list the walker polls the pending vector again. It keeps servicing levels until nothing is pending, and then pulses `done_o`.

The two most urgent levels are reserved for events that should have trapped before any polling took place. Seeing either of them through polling stops the walker for good with `halt_o`. A limit on the number of descriptors walked in one list stops a corrupted, circular chain and raises `err_o`.

Top module: `iw_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `done_o`, `halt_o`, `err_o`, `mem_req_o`, `clr_valid_o` and `disp_valid_o` are all 0.
- R2: A start pulse with no pending bit set produces a one-cycle `done_o` and no memory read, clear or dispatch.
- R3: On every poll the walker picks the lowest-numbered set bit of `pend_i`, where bit 0 is the most urgent level. Levels raised while a run is in progress are serviced in that same order at the next poll.
- R4: For each chosen level, a one-cycle `clr_valid_o` carrying that level on `clr_level_o` comes before any memory read made for that level.
- R5: The first read for a level is at address `VEC_BASE + level`. The word returned is the list head, and a head of zero means an empty list with no dispatch.
- R6: For a descriptor at address P, the type is read at P+1 and the link at P+0. `disp_valid_o` stays high with a stable type and level until `disp_ack_i`, and the link read is issued only after the acknowledge.
- R7: When a list ends, the walker polls again. It repeats while any bit is pending. Otherwise it pulses `done_o` for one cycle and returns to idle.
- R8: If a poll picks a level below `TRAP_LEVELS`, i.e. level 0 or 1 by default, the walker raises `halt_o` and keeps it high until reset. It issues no clear for that level and performs no further reads, clears or dispatches.
- R9: If a list still has a non-null link after `MAX_NODES` descriptors have been dispatched, `err_o` rises and stays set until reset, and the walker returns to idle without `done_o`.
- R10: `mem_req_o` is a one-cycle pulse, and no new request is issued while a read is still awaiting `mem_rvalid_i`.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a service run when idle |
| pend_i | input | NUM_LEVELS | Pending request per level, bit 0 most urgent |
| clr_valid_o | output | 1 | One-cycle request-clear strobe |
| clr_level_o | output | LVL_W | Level whose request is cleared |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | WORD_W | Word address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | WORD_W | Read data word |
| disp_valid_o | output | 1 | Descriptor offered to a handler |
| disp_level_o | output | LVL_W | Level being serviced |
| disp_type_o | output | WORD_W | Device type word of the descriptor |
| disp_ack_i | input | 1 | Handler finished with the descriptor |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when nothing is left pending |
| halt_o | output | 1 | Sticky halt after a trap level was polled |
| err_o | output | 1 | Sticky overrun of the descriptor limit |

## Verification
The bench builds the walker with 16 levels, 8-bit words, the vector table at 0x10 and `MAX_NODES` set to 4. With these values a two-node circular chain reaches the overrun after only four dispatches, and every address, type and link fits in a small array the bench fully controls. The narrow words also keep the link-versus-type ordering of each descriptor visible in every read. Handler acknowledges and read latencies vary from cycle to cycle, and a handler raises new, more urgent levels in the middle of a run, which exercises the re-poll ordering.

// File: rtl/iw_pkg.sv
package iw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_POLL,
    S_CLR,
    S_VREQ,
    S_VWAIT,
    S_CHK,
    S_TREQ,
    S_TWAIT,
    S_DISP,
    S_NREQ,
    S_NWAIT,
    S_HALT
  } iw_state_e;

  typedef enum logic [1:0] {
    A_VEC,
    A_TYPE,
    A_NEXT
  } iw_asel_e;

  // vector table slot of a level
  function automatic logic [63:0] iw_vec_addr(input logic [63:0] base,
                                              input logic [63:0] lvl);
    return base + lvl;
  endfunction

  // type word sits one word above the link word
  function automatic logic [63:0] iw_type_addr(input logic [63:0] ptr);
    return ptr + 64'd1;
  endfunction

  // link word is the first word of a descriptor
  function automatic logic [63:0] iw_link_addr(input logic [63:0] ptr);
    return ptr;
  endfunction

endpackage

// File: rtl/iw_prio_pick.sv
module iw_prio_pick #(
  parameter int N  = 16,
  parameter int LW = 4
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [LW-1:0] level
);
  logic [N:0]   seen_lower;
  logic [N-1:0] first_hot;

  assign seen_lower[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign seen_lower[i+1] = seen_lower[i] | pend[i];
      assign first_hot[i]    = pend[i] & ~seen_lower[i];
    end
  endgenerate

  assign any = seen_lower[N];

  always_comb begin
    level = '0;
    for (int k = 0; k < N; k++) begin
      if (first_hot[k]) level = level | LW'(k);
    end
  end
endmodule

// File: rtl/iw_node_guard.sv
module iw_node_guard #(
  parameter int MAX_NODES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int CNT_W = $clog2(MAX_NODES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign full = (cnt_q == CNT_W'(MAX_NODES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && !full) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/iw_addr_sel.sv
module iw_addr_sel
  import iw_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          LW       = 4,
  parameter logic [W-1:0] VEC_BASE = '0
) (
  input  iw_asel_e      sel,
  input  logic [LW-1:0] lvl,
  input  logic [W-1:0]  ptr,
  output logic [W-1:0]  addr
);
  logic [W-1:0] vec_a, type_a, link_a;

  assign vec_a  = W'(iw_vec_addr(64'(VEC_BASE), 64'(lvl)));
  assign type_a = W'(iw_type_addr(64'(ptr)));
  assign link_a = W'(iw_link_addr(64'(ptr)));

  always_comb begin
    case (sel)
      A_VEC:   addr = vec_a;
      A_TYPE:  addr = type_a;
      default: addr = link_a;
    endcase
  end
endmodule

// File: rtl/iw_walker.sv
module iw_walker
  import iw_pkg::*;
#(
  parameter int           NUM_LEVELS  = 16,
  parameter int           WORD_W      = 32,
  parameter logic [WORD_W-1:0] VEC_BASE = 32'h100,
  parameter int           MAX_NODES   = 1024,
  parameter int           TRAP_LEVELS = 2,
  localparam int          LVL_W       = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NUM_LEVELS-1:0] pend_i,
  output logic              clr_valid_o,
  output logic [LVL_W-1:0]  clr_level_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              disp_valid_o,
  output logic [LVL_W-1:0]  disp_level_o,
  output logic [WORD_W-1:0] disp_type_o,
  input  logic              disp_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              halt_o,
  output logic              err_o
);
  iw_state_e         state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0] type_q;
  logic              done_q;
  logic              err_q;

  logic              pick_any;
  logic [LVL_W-1:0]  pick_lvl;
  logic              guard_full;
  iw_asel_e          asel;

  // named internal events
  logic ev_trap, ev_vec_rd, ev_type_rd, ev_link_rd, ev_list_end, ev_overrun, ev_ack;

  assign ev_trap     = (state_q == S_POLL) && pick_any && (pick_lvl < LVL_W'(TRAP_LEVELS));
  assign ev_vec_rd   = (state_q == S_VWAIT) && mem_rvalid_i;
  assign ev_type_rd  = (state_q == S_TWAIT) && mem_rvalid_i;
  assign ev_link_rd  = (state_q == S_NWAIT) && mem_rvalid_i;
  assign ev_list_end = (state_q == S_CHK) && (ptr_q == '0);
  assign ev_overrun  = (state_q == S_CHK) && (ptr_q != '0) && guard_full;
  assign ev_ack      = (state_q == S_DISP) && disp_ack_i;

  iw_prio_pick #(.N(NUM_LEVELS), .LW(LVL_W)) pick_i (
    .pend  (pend_i),
    .any   (pick_any),
    .level (pick_lvl)
  );

  iw_node_guard #(.MAX_NODES(MAX_NODES)) guard_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_vec_rd),
    .inc   (ev_link_rd),
    .full  (guard_full)
  );

  always_comb begin
    case (state_q)
      S_VREQ:  asel = A_VEC;
      S_TREQ:  asel = A_TYPE;
      default: asel = A_NEXT;
    endcase
  end

  iw_addr_sel #(.W(WORD_W), .LW(LVL_W), .VEC_BASE(VEC_BASE)) addr_i (
    .sel  (asel),
    .lvl  (lvl_q),
    .ptr  (ptr_q),
    .addr (mem_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      ptr_q   <= '0;
      type_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE:  if (start_i) state_q <= S_POLL;
        S_POLL: begin
          if (!pick_any) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (ev_trap) begin
            state_q <= S_HALT;
          end else begin
            lvl_q   <= pick_lvl;
            state_q <= S_CLR;
          end
        end
        S_CLR:   state_q <= S_VREQ;
        S_VREQ:  state_q <= S_VWAIT;
        S_VWAIT: if (ev_vec_rd) begin
          ptr_q   <= mem_rdata_i;
          state_q <= S_CHK;
        end
        S_CHK: begin
          if (ev_list_end) begin
            state_q <= S_POLL;
          end else if (ev_overrun) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_TREQ;
          end
        end
        S_TREQ:  state_q <= S_TWAIT;
        S_TWAIT: if (ev_type_rd) begin
          type_q  <= mem_rdata_i;
          state_q <= S_DISP;
        end
        S_DISP:  if (ev_ack) state_q <= S_NREQ;
        S_NREQ:  state_q <= S_NWAIT;
        S_NWAIT: if (ev_link_rd) begin
          ptr_q   <= mem_rdata_i;
          state_q <= S_CHK;
        end
        S_HALT:  state_q <= S_HALT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign clr_valid_o  = (state_q == S_CLR);
  assign clr_level_o  = lvl_q;
  assign mem_req_o    = (state_q == S_VREQ) || (state_q == S_TREQ) || (state_q == S_NREQ);
  assign disp_valid_o = (state_q == S_DISP);
  assign disp_level_o = lvl_q;
  assign disp_type_o  = type_q;
  assign busy_o       = (state_q != S_IDLE) && (state_q != S_HALT);
  assign done_o       = done_q;
  assign halt_o       = (state_q == S_HALT);
  assign err_o        = err_q;
endmodule

// File: rtl/iw_walker_chk.sv
module iw_walker_chk #(
  parameter int WORD_W      = 32,
  parameter int LVL_W       = 4,
  parameter int TRAP_LEVELS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_valid_o,
  input logic [LVL_W-1:0]  clr_level_o,
  input logic              mem_req_o,
  input logic              mem_rvalid_i,
  input logic              disp_valid_o,
  input logic [LVL_W-1:0]  disp_level_o,
  input logic [WORD_W-1:0] disp_type_o,
  input logic              disp_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              halt_o,
  input logic              err_o
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outst_q <= 1'b0;
    else if (mem_req_o)    outst_q <= 1'b1;
    else if (mem_rvalid_i) outst_q <= 1'b0;
  end

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !outst_q);

  assert_disp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && !disp_ack_i) |=> (disp_valid_o && $stable(disp_type_o) && $stable(disp_level_o)));

  assert_no_read_in_disp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> !mem_req_o);

  assert_clr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid_o |=> !clr_valid_o);

  assert_no_trap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid_o |-> (clr_level_o >= LVL_W'(TRAP_LEVELS)));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (!mem_req_o && !clr_valid_o && !disp_valid_o && !busy_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind iw_walker iw_walker_chk #(
  .WORD_W      (WORD_W),
  .LVL_W       (LVL_W),
  .TRAP_LEVELS (TRAP_LEVELS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_valid_o  (clr_valid_o),
  .clr_level_o  (clr_level_o),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .disp_valid_o (disp_valid_o),
  .disp_level_o (disp_level_o),
  .disp_type_o  (disp_type_o),
  .disp_ack_i   (disp_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .halt_o       (halt_o),
  .err_o        (err_o)
);

// File: tb/iw_walker_tb_top.sv
module iw_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 16;
  localparam int WW   = 8;
  localparam int LW   = 4;
  localparam int MAXN = 4;
  localparam logic [7:0] VB = 8'h10;
  localparam int WD_CYCLES = 50000;

  localparam int K_CLR = 1, K_DISP = 2, K_DONE = 3, K_HALT = 4, K_ERR = 5, K_MEM = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NL-1:0] pend_i = '0;
  logic          clr_valid_o;
  logic [LW-1:0] clr_level_o;
  logic          mem_req_o;
  logic [WW-1:0] mem_addr_o;
  logic          mem_rvalid_i = 1'b0;
  logic [WW-1:0] mem_rdata_i = '0;
  logic          disp_valid_o;
  logic [LW-1:0] disp_level_o;
  logic [WW-1:0] disp_type_o;
  logic          disp_ack_i = 1'b0;
  logic          busy_o, done_o, halt_o, err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  iw_walker #(
    .NUM_LEVELS(NL), .WORD_W(WW), .VEC_BASE(VB), .MAX_NODES(MAXN), .TRAP_LEVELS(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pend_i(pend_i),
    .clr_valid_o(clr_valid_o), .clr_level_o(clr_level_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .disp_valid_o(disp_valid_o), .disp_level_o(disp_level_o),
    .disp_type_o(disp_type_o), .disp_ack_i(disp_ack_i),
    .busy_o(busy_o), .done_o(done_o), .halt_o(halt_o), .err_o(err_o)
  );

  logic [7:0] mem [256];
  longint     exp_q[$];
  int         n_chk = 0;
  int         n_err = 0;
  logic       trig_arm = 1'b0;
  logic [7:0] trig_type = '0;
  logic [NL-1:0] trig_mask = '0;

  function automatic longint ev(input int k, input int l, input int v);
    return (longint'(k) << 40) | (longint'(l) << 32) | longint'(v);
  endfunction

  function automatic string req_of(input longint e);
    case (int'(e >> 40))
      K_CLR:  return "R4";
      K_DISP: return "R6";
      K_DONE: return "R7";
      K_HALT: return "R8";
      K_ERR:  return "R9";
      default: return "R5/R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic observe(input longint e);
    if (exp_q.size() == 0) begin
      chk(1'b0, req_of(e), e, 0);
    end else begin
      longint x;
      x = exp_q.pop_front();
      chk(e == x, req_of(x), e, x);
    end
  endtask

  // behavioural reference: walks the bench memory the way the requirements say
  task automatic model_run(input logic [NL-1:0] p_in, input bit arm);
    logic [NL-1:0] p;
    bit armed;
    p = p_in;
    armed = arm;
    while (p != '0) begin
      int l;
      logic [7:0] ptr;
      int cnt;
      l = 0;
      for (int i = NL-1; i >= 0; i--) if (p[i]) l = i;   // R3 lowest index wins
      if (l < 2) begin exp_q.push_back(ev(K_HALT, 0, 0)); return; end
      exp_q.push_back(ev(K_CLR, l, 0));
      p[l] = 1'b0;
      exp_q.push_back(ev(K_MEM, 0, int'(VB + 8'(l))));
      ptr = mem[VB + 8'(l)];
      cnt = 0;
      while (ptr != 8'h00) begin
        logic [7:0] t;
        if (cnt == MAXN) begin exp_q.push_back(ev(K_ERR, 0, 0)); return; end
        exp_q.push_back(ev(K_MEM, 0, int'(ptr + 8'd1)));
        t = mem[ptr + 8'd1];
        exp_q.push_back(ev(K_DISP, l, int'(t)));
        if (armed && t == trig_type) begin p = p | trig_mask; armed = 1'b0; end
        exp_q.push_back(ev(K_MEM, 0, int'(ptr)));
        ptr = mem[ptr];
        cnt++;
      end
    end
    exp_q.push_back(ev(K_DONE, 0, 0));
  endtask

  task automatic responder();
    int nrd;
    nrd = 0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_o) begin
        logic [7:0] a;
        a = mem_addr_o;
        repeat (1 + (nrd % 3)) @(negedge clk);
        nrd++;
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem[a];
        @(negedge clk);
        mem_rvalid_i = 1'b0;
      end
    end
  endtask

  task automatic acker();
    int nd;
    nd = 0;
    forever begin
      @(negedge clk);
      if (rst_n && disp_valid_o && !disp_ack_i) begin
        repeat (nd % 3) @(negedge clk);
        nd++;
        disp_ack_i = 1'b1;
        @(negedge clk);
        disp_ack_i = 1'b0;
      end
    end
  endtask

  task automatic monitor();
    bit disp_prev, halt_prev, err_prev, req_prev;
    disp_prev = 0; halt_prev = 0; err_prev = 0; req_prev = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_req_o) begin
          chk(!req_prev, "R10", 1, 0);   // one-cycle request pulse
          observe(ev(K_MEM, 0, int'(mem_addr_o)));
        end
        if (clr_valid_o) begin
          observe(ev(K_CLR, int'(clr_level_o), 0));
          pend_i[clr_level_o] = 1'b0;
        end
        if (disp_valid_o && !disp_prev) begin
          observe(ev(K_DISP, int'(disp_level_o), int'(disp_type_o)));
          if (trig_arm && disp_type_o == trig_type) begin
            pend_i   = pend_i | trig_mask;
            trig_arm = 1'b0;
          end
        end
        if (done_o) observe(ev(K_DONE, 0, 0));
        if (halt_o && !halt_prev) observe(ev(K_HALT, 0, 0));
        if (err_o && !err_prev) observe(ev(K_ERR, 0, 0));
      end
      disp_prev = disp_valid_o; halt_prev = halt_o; err_prev = err_o; req_prev = mem_req_o;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pend_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_case(input logic [NL-1:0] p, input bit arm, input string req);
    model_run(p, arm);
    trig_arm = arm;
    pend_i = p;
    pulse_start();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!busy_o && exp_q.size() == 0) break;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(!busy_o, req, busy_o, 0);
  endtask

  task automatic run_all();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // level 5: three nodes
    mem[VB + 5] = 8'h40;
    mem[8'h40] = 8'h50; mem[8'h41] = 8'h11;
    mem[8'h50] = 8'h60; mem[8'h51] = 8'h12;
    mem[8'h60] = 8'h00; mem[8'h61] = 8'h13;
    // level 4: one node, level 7: empty, level 9: two nodes
    mem[VB + 4] = 8'h70; mem[8'h70] = 8'h00; mem[8'h71] = 8'h21;
    mem[VB + 9] = 8'h80;
    mem[8'h80] = 8'h88; mem[8'h81] = 8'h31;
    mem[8'h88] = 8'h00; mem[8'h89] = 8'h32;
    // level 10 raises 3 and 14 from its first handler
    mem[VB + 10] = 8'h90;
    mem[8'h90] = 8'h98; mem[8'h91] = 8'hA2;
    mem[8'h98] = 8'h00; mem[8'h99] = 8'hA3;
    mem[VB + 3]  = 8'hA0; mem[8'hA0] = 8'h00; mem[8'hA1] = 8'h33;
    mem[VB + 14] = 8'hB0; mem[8'hB0] = 8'h00; mem[8'hB1] = 8'h44;
    // level 6: circular chain
    mem[VB + 6] = 8'hC0;
    mem[8'hC0] = 8'hC8; mem[8'hC1] = 8'h61;
    mem[8'hC8] = 8'hC0; mem[8'hC9] = 8'h62;

    do_reset();
    // R1 reset state
    chk(!busy_o && !done_o && !halt_o && !err_o, "R1", {busy_o, done_o, halt_o, err_o}, 0);
    chk(!mem_req_o && !clr_valid_o && !disp_valid_o, "R1",
        {mem_req_o, clr_valid_o, disp_valid_o}, 0);

    // R2 nothing pending
    run_case('0, 1'b0, "R2");

    // R5 R6 single level, three descriptors
    run_case(NL'(1) << 5, 1'b0, "R6");

    // R3 R5 several levels at once, one with an empty list
    run_case((NL'(1) << 9) | (NL'(1) << 4) | (NL'(1) << 7), 1'b0, "R3");

    // R7 R11 handler raises more urgent and less urgent levels; start while busy
    trig_type = 8'hA2;
    trig_mask = (NL'(1) << 3) | (NL'(1) << 14);
    model_run(NL'(1) << 10, 1'b1);
    trig_arm = 1'b1;
    pend_i = NL'(1) << 10;
    pulse_start();
    repeat (4) @(negedge clk);
    chk(busy_o, "R11", busy_o, 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!busy_o && exp_q.size() == 0) break;
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    chk(!busy_o, "R11", busy_o, 0);

    // R9 circular chain trips the limit
    run_case(NL'(1) << 6, 1'b0, "R9");
    chk(err_o, "R9", err_o, 1);
    chk(!done_o, "R9", done_o, 0);

    // R8 trap level seen through polling
    do_reset();
    chk(!err_o, "R1", err_o, 0);
    model_run((NL'(1) << 1) | (NL'(1) << 8), 1'b0);
    pend_i = (NL'(1) << 1) | (NL'(1) << 8);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(halt_o, "R8", halt_o, 1);
    chk(!busy_o, "R8", busy_o, 0);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    chk(pend_i[8], "R8", pend_i[8], 1);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      responder();
      acker();
      monitor();
    join_none
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule